// File: doc/BRIEF.md
# Slotted Local-Bus Decoder with Endian Adjust

This block connects a host-side local bus to four plug-in module slots. The host presents an access on one of four windows: a configuration window, a slot register window, a halfword memory window or a byte memory window. The block slices the address into a slot number, an address space and an offset. It then issues a single-cycle strobe on the selected slot, carrying the direction, space code, offset and write data. A read is answered two cycles after it is accepted, with the data the module returns in the cycle after the strobe.

Each of the register and halfword windows has its own big-endian mode bit, held in the configuration window. When the bit is set, byte accesses have address bit 0 inverted before slicing, and halfword accesses have their two data bytes exchanged on both write and read data. A read of offset 0 or 2 in a slot's interrupt space also sends a one-cycle acknowledge to the interrupt logic, but only for a line whose status is set and which is configured as level-sensitive. Accesses to empty slots, and halfword accesses to the byte window, produce no strobe. When such an access is a read, it returns zero.

Control is a three-state machine. ST_IDLE accepts a request (`req_valid` while `req_ready`) and moves to ST_ISSUE. ST_ISSUE drives the strobe and acknowledge for one cycle, then returns to ST_IDLE for a write or moves to ST_REPLY for a read. ST_REPLY raises `rsp_valid` with the read data for one cycle and returns to ST_IDLE.

Top module: `slot_bus_decoder`

## Requirements
- R1: In the register window (`req_win`=1) address bits [9:8] give the slot and bits [7:6] the space: 2 is ID space, 3 is interrupt space, 0 and 1 are I/O space. The space is forwarded on `mod_space` as I/O=0, ID=1, interrupt=2, halfword memory=3, byte memory=4.
- R2: The forwarded offset is the address masked to bits [6:0] for I/O space and to bits [5:0] for ID and interrupt space. All higher offset bits are zero.
- R3: In the halfword memory window (`req_win`=2) address bits [24:23] give the slot and bits [22:0] the offset.
- R4: In the byte memory window (`req_win`=3) bits [23:22] give the slot and bits [21:0] the offset. Bit 24 is ignored and no endian adjustment is applied. A halfword access (`req_half`=1) to this window issues no strobe, and a read of this kind returns 0.
- R5: With big-endian mode on for the register or halfword window, a byte access inverts address bit 0 before slicing.
- R6: With big-endian mode on for that window, a halfword access exchanges bytes [15:8] and [7:0] of the forwarded write data and of the returned read data.
- R7: In the configuration window (`req_win`=0, offset = address bits [6:0]), bit 0 of offsets 0x2B, 0x2F and 0x33 holds the mode bits. 0x2F holds the register window's bit, 0x33 the halfword window's bit, and 0x2B a retained bit that steers neither. Reading returns the bit in data bit 0, and zero elsewhere. Writes to any other offset change nothing, and reads of them return 0.
- R8: A read of interrupt-space offset 0 (line 0) or 2 (line 1) pulses `int_ack[2*slot+line]` in the strobe cycle. This happens only if `int_status` of that line is 1 and `int_edge` is 0; otherwise `int_ack` stays 0.
- R9: An access to a slot whose `slot_present` bit is 0 issues no strobe and no acknowledge, and a read of it returns 0.
- R10: A request is accepted when `req_valid` and `req_ready` are both high. One cycle later there is at most one strobe bit, high for exactly one cycle. For a read, `rsp_valid` is high two cycles after acceptance, returning the selected slot's `mod_rdata` as it stands in that cycle. Writes produce no response.
- R11: After reset the machine is in ST_IDLE with `req_ready` high and no strobe, acknowledge or response, and all three mode bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request (ST_IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 2 | Window: 0 config, 1 register, 2 halfword memory, 3 byte memory |
| req_half | input | 1 | 1 = halfword access, 0 = byte access |
| req_addr | input | 25 | Address within the window |
| req_wdata | input | 16 | Host write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 16 | Read data to host |
| slot_present | input | 4 | Module installed per slot |
| int_status | input | 8 | Pending status per slot line, index 2*slot+line |
| int_edge | input | 8 | 1 = line is edge-sensitive, index 2*slot+line |
| mod_stb | output | 4 | One-cycle access strobe per slot |
| mod_we | output | 1 | Forwarded direction |
| mod_space | output | 3 | Forwarded space code |
| mod_offset | output | 23 | Forwarded offset |
| mod_wdata | output | 16 | Forwarded write data |
| mod_rdata | input | 64 | Read data per slot, slot n on bits [16n+15:16n] |
| int_ack | output | 8 | Level-interrupt acknowledge pulse, index 2*slot+line |

## Verification
The assertions assume that `slot_present` does not change while an access is in flight. This matters because the check that no strobe lands on an empty slot compares the strobe against the present vector in the issue cycle. The acknowledge checks compare the pulse with the status and edge inputs sampled at acceptance. The stimulus holds `slot_present`, `int_status` and `int_edge` constant for the whole run. It raises `req_valid` only while `req_ready` is high and keeps it high for a single cycle. The bench's module model registers read data on each strobe, so `mod_rdata` is stable in the response cycle.

// File: rtl/sbd_pkg.sv
`timescale 1ns/1ps
package sbd_pkg;
    localparam int NUM_SLOTS     = 4;
    localparam int SLOT_W        = $clog2(NUM_SLOTS);
    localparam int LINES         = 2;
    localparam int ACK_W         = NUM_SLOTS * LINES;
    localparam int DATA_W        = 16;
    localparam int ADDR_W        = 25;
    localparam int OFF_W         = 23;
    localparam int REG_SLOT_LSB  = 8;
    localparam int REG_SPC_LSB   = 6;
    localparam int IO_OFF_W      = 7;
    localparam int IDINT_OFF_W   = 6;
    localparam int HALF_SLOT_LSB = 23;
    localparam int BYTE_SLOT_LSB = 22;
    localparam int CFG_OFF_W     = 7;
    localparam int NUM_MODE      = 3;
    localparam int CFG_MODE_BASE = 'h2B;
    localparam int CFG_MODE_STEP = 4;

    typedef enum logic [1:0] {
        WIN_CFG  = 2'd0,
        WIN_REGS = 2'd1,
        WIN_HALF = 2'd2,
        WIN_BYTE = 2'd3
    } win_e;

    typedef enum logic [2:0] {
        SP_IO    = 3'd0,
        SP_ID    = 3'd1,
        SP_INT   = 3'd2,
        SP_MEM16 = 3'd3,
        SP_MEM8  = 3'd4
    } space_e;

    typedef struct packed {
        logic              ok;
        logic [SLOT_W-1:0] slot;
        space_e            space;
        logic [OFF_W-1:0]  off;
        logic              swap;
        logic              ack_try;
        logic              ack_line;
    } dec_t;
endpackage

// File: rtl/sbd_lane_swap.sv
`timescale 1ns/1ps
module sbd_lane_swap #(
    parameter int W = 16
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LANES = W / 8;
    logic [W-1:0] rev;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign rev[k*8 +: 8] = din[(LANES-1-k)*8 +: 8];
    end

    assign dout = en ? rev : din;
endmodule

// File: rtl/sbd_cfg_regs.sv
`timescale 1ns/1ps
module sbd_cfg_regs
    import sbd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CFG_OFF_W-1:0] offset,
    input  logic                 wbit,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_MODE-1:0]  mode
);
    logic [NUM_MODE-1:0] hit;

    for (genvar i = 0; i < NUM_MODE; i++) begin : g_mode
        localparam logic [CFG_OFF_W-1:0] MY_OFF =
            CFG_OFF_W'(CFG_MODE_BASE + i * CFG_MODE_STEP);
        assign hit[i] = (offset == MY_OFF);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mode[i] <= 1'b0;
            else if (wr_en && hit[i])
                mode[i] <= wbit;
        end
    end

    assign rd_data = DATA_W'(|(hit & mode));
endmodule

// File: rtl/sbd_decode.sv
`timescale 1ns/1ps
module sbd_decode
    import sbd_pkg::*;
(
    input  win_e                win,
    input  logic                half,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_MODE-1:0] mode,
    output dec_t                dec
);
    logic [3:0]        mode_by_win;
    logic              be;
    logic [ADDR_W-1:0] a;

    // byte window never carries a mode bit
    assign mode_by_win = {1'b0, mode};
    assign be          = mode_by_win[win];
    assign a           = addr ^ ADDR_W'(be && !half);

    always_comb begin
        dec          = '0;
        dec.swap     = be && half;
        unique case (win)
            WIN_REGS: begin
                dec.ok   = 1'b1;
                dec.slot = a[REG_SLOT_LSB +: SLOT_W];
                case (a[REG_SPC_LSB +: 2])
                    2'd2: begin
                        dec.space = SP_ID;
                        dec.off   = OFF_W'(a[IDINT_OFF_W-1:0]);
                    end
                    2'd3: begin
                        dec.space = SP_INT;
                        dec.off   = OFF_W'(a[IDINT_OFF_W-1:0]);
                    end
                    default: begin
                        dec.space = SP_IO;
                        dec.off   = OFF_W'(a[IO_OFF_W-1:0]);
                    end
                endcase
            end
            WIN_HALF: begin
                dec.ok    = 1'b1;
                dec.slot  = a[HALF_SLOT_LSB +: SLOT_W];
                dec.space = SP_MEM16;
                dec.off   = a[OFF_W-1:0];
            end
            WIN_BYTE: begin
                dec.ok    = !half;
                dec.slot  = a[BYTE_SLOT_LSB +: SLOT_W];
                dec.space = SP_MEM8;
                dec.off   = OFF_W'(a[BYTE_SLOT_LSB-1:0]);
            end
            WIN_CFG: begin
                dec.ok = 1'b0;
            end
        endcase
        dec.ack_try  = (win == WIN_REGS) && (dec.space == SP_INT) &&
                       (dec.off[OFF_W-1:2] == '0) && !dec.off[0];
        dec.ack_line = dec.off[1];
    end
endmodule

// File: rtl/slot_bus_decoder.sv
`timescale 1ns/1ps
module slot_bus_decoder
    import sbd_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_write,
    input  logic [1:0]                  req_win,
    input  logic                        req_half,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           req_wdata,
    output logic                        rsp_valid,
    output logic [DATA_W-1:0]           rsp_rdata,
    input  logic [NUM_SLOTS-1:0]        slot_present,
    input  logic [ACK_W-1:0]            int_status,
    input  logic [ACK_W-1:0]            int_edge,
    output logic [NUM_SLOTS-1:0]        mod_stb,
    output logic                        mod_we,
    output logic [2:0]                  mod_space,
    output logic [OFF_W-1:0]            mod_offset,
    output logic [DATA_W-1:0]           mod_wdata,
    input  logic [NUM_SLOTS*DATA_W-1:0] mod_rdata,
    output logic [ACK_W-1:0]            int_ack
);
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_REPLY = 2'd2
    } state_e;

    state_e              state_q, state_d;
    win_e                win;
    dec_t                dec;
    logic [NUM_MODE-1:0] mode;
    logic [DATA_W-1:0]   cfg_rd, wdata_sw, slot_rd, slot_rd_sw;
    logic                accept, fwd;
    logic [SLOT_W:0]     ack_idx;

    logic [SLOT_W-1:0]   slot_q;
    logic                fwd_q, swap_q;
    logic [ACK_W-1:0]    ack_q;
    logic [DATA_W-1:0]   cfg_q;

    assign win     = win_e'(req_win);
    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign fwd     = dec.ok && slot_present[dec.slot];
    assign ack_idx = {dec.slot, dec.ack_line};

    sbd_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept && req_write && (win == WIN_CFG)),
        .offset  (req_addr[CFG_OFF_W-1:0]),
        .wbit    (req_wdata[0]),
        .rd_data (cfg_rd),
        .mode    (mode)
    );

    sbd_decode u_dec (
        .win  (win),
        .half (req_half),
        .addr (req_addr),
        .mode (mode),
        .dec  (dec)
    );

    sbd_lane_swap #(.W(DATA_W)) u_wswap (
        .en   (dec.swap),
        .din  (req_wdata),
        .dout (wdata_sw)
    );

    assign slot_rd = mod_rdata[int'(slot_q)*DATA_W +: DATA_W];

    sbd_lane_swap #(.W(DATA_W)) u_rswap (
        .en   (swap_q),
        .din  (slot_rd),
        .dout (slot_rd_sw)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ISSUE;
            ST_ISSUE: state_d = mod_we ? ST_IDLE : ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // request capture at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q     <= '0;
            fwd_q      <= 1'b0;
            swap_q     <= 1'b0;
            ack_q      <= '0;
            cfg_q      <= '0;
            mod_we     <= 1'b0;
            mod_space  <= '0;
            mod_offset <= '0;
            mod_wdata  <= '0;
        end else if (accept) begin
            slot_q     <= dec.slot;
            fwd_q      <= fwd;
            swap_q     <= dec.swap;
            cfg_q      <= (win == WIN_CFG) ? cfg_rd : '0;
            mod_we     <= req_write;
            mod_space  <= dec.space;
            mod_offset <= dec.off;
            mod_wdata  <= wdata_sw;
            if (dec.ack_try && fwd && !req_write &&
                int_status[ack_idx] && !int_edge[ack_idx])
                ack_q <= ACK_W'(1) << ack_idx;
            else
                ack_q <= '0;
        end
    end

    // outputs by state
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        mod_stb   = '0;
        int_ack   = '0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: begin
                if (fwd_q) mod_stb[slot_q] = 1'b1;
                int_ack = ack_q;
            end
            ST_REPLY: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign rsp_rdata = fwd_q ? slot_rd_sw : cfg_q;

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mod_stb)); // R10
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|mod_stb) |=> (mod_stb == '0)); // R10
    AST_RSP_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready); // R10
    AST_STB_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        (|mod_stb) |-> ((mod_stb & ~slot_present) == '0)); // R9
    AST_ACK_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (|int_ack) |-> ((int_ack & $past(int_status) & ~$past(int_edge)) == int_ack)); // R8
    AST_ACK_ON_INT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (|int_ack) |-> ((|mod_stb) && !mod_we && (mod_space == 3'(SP_INT)))); // R8
    AST_SHORT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        ((|mod_stb) && (mod_space <= 3'(SP_INT))) |-> (mod_offset[OFF_W-1:IO_OFF_W] == '0)); // R2
endmodule

// File: tb/slot_bus_decoder_tb.sv
`timescale 1ns/1ps
module slot_bus_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_half = 1'b0;
    logic [1:0]  req_win = '0;
    logic [24:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid, mod_we;
    logic [15:0] rsp_rdata, mod_wdata;
    logic [3:0]  slot_present = 4'b1011;
    logic [7:0]  int_status = 8'b1100_0111;
    logic [7:0]  int_edge   = 8'b0100_0000;
    logic [3:0]  mod_stb;
    logic [2:0]  mod_space;
    logic [22:0] mod_offset;
    logic [63:0] mod_rdata;
    logic [7:0]  int_ack;

    always #2.5 clk = ~clk;

    slot_bus_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_win(req_win), .req_half(req_half),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .slot_present(slot_present),
        .int_status(int_status), .int_edge(int_edge), .mod_stb(mod_stb),
        .mod_we(mod_we), .mod_space(mod_space), .mod_offset(mod_offset),
        .mod_wdata(mod_wdata), .mod_rdata(mod_rdata), .int_ack(int_ack)
    );

    // module model: registers read data on its strobe
    logic [15:0] rd_reg [4];
    always @(posedge clk) begin
        for (int i = 0; i < 4; i++)
            if (mod_stb[i] && !mod_we)
                rd_reg[i] <= {2'(i), mod_space, mod_offset[10:0]};
    end
    assign mod_rdata = {rd_reg[3], rd_reg[2], rd_reg[1], rd_reg[0]};

    typedef struct packed {
        logic [3:0]  stb;
        logic        we;
        logic [2:0]  sp;
        logic [22:0] off;
        logic [15:0] wd;
        logic [7:0]  ack;
    } iss_t;

    iss_t        iss_q[$];
    string       iss_tag[$];
    logic [15:0] rsp_q[$];
    string       rsp_tag[$];
    logic [2:0]  be_m = '0;
    int          tests = 0, fails = 0;
    logic        acc_seen = 1'b0;
    bit          done = 1'b0;

    always @(posedge clk) acc_seen <= rst_n && req_valid && req_ready;

    function automatic logic [15:0] swap16(input logic [15:0] d);
        return {d[7:0], d[15:8]};
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (acc_seen) begin
                iss_t  e;
                string t;
                logic  ok;
                e = iss_q.pop_front();
                t = iss_tag.pop_front();
                tests++;
                ok = (mod_stb == e.stb) && (int_ack == e.ack);
                if (e.stb != 0)
                    ok = ok && (mod_we == e.we) && (mod_space == e.sp) &&
                         (mod_offset == e.off) && (!e.we || mod_wdata == e.wd);
                if (!ok) begin
                    fails++;
                    $display("FAIL %s issue: stb=%b we=%b sp=%0d off=%h wd=%h ack=%b expected stb=%b we=%b sp=%0d off=%h wd=%h ack=%b",
                             t, mod_stb, mod_we, mod_space, mod_offset, mod_wdata, int_ack,
                             e.stb, e.we, e.sp, e.off, e.wd, e.ack);
                end
            end
            if (rsp_valid) begin
                tests++;
                if (rsp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R10 unexpected response: rdata=%h expected none", rsp_rdata);
                end else begin
                    logic [15:0] x;
                    string       t;
                    x = rsp_q.pop_front();
                    t = rsp_tag.pop_front();
                    if (rsp_rdata !== x) begin
                        fails++;
                        $display("FAIL %s read: rdata=%h expected %h", t, rsp_rdata, x);
                    end
                end
            end
        end
    end

    // driver: computes the expectation from the requirements, then drives
    task automatic acc(input logic [1:0] win, input logic wr, input logic half,
                       input logic [24:0] addr, input logic [15:0] wd, input string tag);
        logic [24:0] a;
        logic        be, ok;
        logic [1:0]  slot;
        logic [2:0]  sp;
        logic [22:0] off;
        logic [15:0] rd;
        iss_t        e;
        int          idx;
        be = (win == 2'd1) ? be_m[1] : (win == 2'd2) ? be_m[2] : 1'b0;
        a  = addr;
        if (be && !half) a[0] = ~a[0];
        ok = 1'b1; slot = '0; sp = '0; off = '0;
        case (win)
            2'd1: begin
                slot = a[9:8];
                sp   = (a[7:6] == 2'd2) ? 3'd1 : (a[7:6] == 2'd3) ? 3'd2 : 3'd0;
                off  = (sp == 3'd0) ? {16'b0, a[6:0]} : {17'b0, a[5:0]};
            end
            2'd2: begin slot = a[24:23]; sp = 3'd3; off = a[22:0]; end
            2'd3: begin slot = a[23:22]; sp = 3'd4; off = {1'b0, a[21:0]}; ok = !half; end
            default: ok = 1'b0;
        endcase
        e  = '0;
        rd = '0;
        if (ok && slot_present[slot]) begin
            e.stb = 4'b0001 << slot;
            e.we  = wr;
            e.sp  = sp;
            e.off = off;
            e.wd  = (be && half) ? swap16(wd) : wd;
            if (!wr && win == 2'd1 && sp == 3'd2 && (off == 23'd0 || off == 23'd2)) begin
                idx = slot * 2 + int'(off[1]);
                if (int_status[idx] && !int_edge[idx]) e.ack[idx] = 1'b1;
            end
            rd = {slot, sp, off[10:0]};
            if (be && half) rd = swap16(rd);
        end
        if (win == 2'd0) begin
            case (addr[6:0])
                7'h2B: rd = {15'b0, be_m[0]};
                7'h2F: rd = {15'b0, be_m[1]};
                7'h33: rd = {15'b0, be_m[2]};
                default: rd = '0;
            endcase
            if (wr) begin
                case (addr[6:0])
                    7'h2B: be_m[0] = wd[0];
                    7'h2F: be_m[1] = wd[0];
                    7'h33: be_m[2] = wd[0];
                    default: ;
                endcase
            end
        end
        iss_q.push_back(e);
        iss_tag.push_back(tag);
        if (!wr) begin
            rsp_q.push_back(rd);
            rsp_tag.push_back(tag);
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_win = win; req_half = half;
        req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if (!(req_ready === 1'b1 && mod_stb === 4'b0 && int_ack === 8'b0 && rsp_valid === 1'b0)) begin
            fails++;
            $display("FAIL R11 reset: ready=%b stb=%b ack=%b rsp=%b expected 1 0000 00000000 0",
                     req_ready, mod_stb, int_ack, rsp_valid);
        end
        acc(2'd0, 0, 1, 25'h2F, 16'h0, "R11 mode bit clear");
        acc(2'd1, 0, 0, 25'h155, 16'h0, "R1 R2 io space");
        acc(2'd1, 1, 1, 25'h3AA, 16'h1234, "R1 id space write");
        acc(2'd1, 0, 1, 25'h0C0, 16'h0, "R8 ack slot0 line0");
        acc(2'd1, 0, 1, 25'h1C2, 16'h0, "R8 status clear no ack");
        acc(2'd1, 0, 1, 25'h3C0, 16'h0, "R8 edge line no ack");
        acc(2'd1, 0, 1, 25'h3C2, 16'h0, "R8 ack slot3 line1");
        acc(2'd1, 0, 1, 25'h0C4, 16'h0, "R8 other offset no ack");
        acc(2'd1, 0, 1, 25'h2C0, 16'h0, "R9 absent read");
        acc(2'd1, 1, 1, 25'h210, 16'hBEEF, "R9 absent write");
        acc(2'd2, 0, 1, {2'b11, 23'h123456}, 16'h0, "R3 halfword window");
        acc(2'd2, 1, 1, {2'b00, 23'h7FFFFE}, 16'h5A5A, "R3 halfword write");
        acc(2'd3, 0, 0, {1'b1, 2'b01, 22'h2ABCDE}, 16'h0, "R4 byte window");
        acc(2'd3, 0, 1, {1'b0, 2'b01, 22'h000010}, 16'h0, "R4 halfword rejected");
        acc(2'd0, 1, 0, 25'h2F, 16'h0001, "R7 set register mode");
        acc(2'd0, 1, 0, 25'h33, 16'h0001, "R7 set halfword mode");
        acc(2'd0, 1, 0, 25'h30, 16'h0001, "R7 other offset write");
        acc(2'd0, 0, 0, 25'h2F, 16'h0, "R7 read register mode");
        acc(2'd0, 0, 0, 25'h33, 16'h0, "R7 read halfword mode");
        acc(2'd0, 0, 0, 25'h30, 16'h0, "R7 other offset reads 0");
        acc(2'd0, 0, 0, 25'h2B, 16'h0, "R7 retained bit clear");
        acc(2'd1, 0, 0, 25'h0C1, 16'h0, "R5 flipped int ack");
        acc(2'd1, 1, 1, 25'h110, 16'hA1B2, "R6 write swap");
        acc(2'd1, 0, 1, 25'h110, 16'h0, "R6 read swap");
        acc(2'd2, 0, 0, {2'b01, 23'h000101}, 16'h0, "R5 halfword window byte");
        acc(2'd3, 0, 0, {1'b0, 2'b11, 22'h000001}, 16'h0, "R4 no endian adjust");
        acc(2'd0, 1, 0, 25'h2B, 16'h0001, "R7 retained bit set");
        acc(2'd3, 0, 0, {1'b0, 2'b00, 22'h000003}, 16'h0, "R4 retained bit no effect");
        acc(2'd0, 1, 0, 25'h2F, 16'h0000, "R7 clear register mode");
        acc(2'd1, 0, 0, 25'h001, 16'h0, "R5 flip off again");
        repeat (3) @(negedge clk);
        tests++;
        if (iss_q.size() != 0 || rsp_q.size() != 0) begin
            fails++;
            $display("FAIL R10 pending: issue=%0d rsp=%0d expected 0 0", iss_q.size(), rsp_q.size());
        end
        finish_run();
    end
endmodule